// File: doc/BRIEF.md
# Rotating-Parity Stripe Mapper and Small-Write Sequencer

This block turns a logical block number into a physical place in a five-column disk array with distributed parity. Each stripe row holds four data blocks and one parity block, and the parity block moves one column to the left from one row to the next. The column therefore follows a five-row cycle. The block accepts one single-block write at a time and expands it into the four physical commands a small write needs. It reads the old data, reads the old parity, writes the new data and then writes the new parity. The new parity is built by XOR-ing the returned words with the new data.

Commands leave the block on a valid/ready port. Each command carries a column, a row, a write flag and a write word. Read results come back on a one-cycle response strobe. A single-cycle completion pulse marks the acknowledgement of the final parity write. While a write is in progress, no new write is taken.

Top module: `parity_stripe_writer`

## Requirements
- R1: After reset the block offers no command (`cmd_valid` = 0), reports no completion (`done` = 0) and is ready for a write (`wr_ready` = 1).
- R2: Every command of a write to logical block L carries row L / 4, using integer division.
- R3: The parity commands use column 4 − (row mod 5). Row 0 puts parity in column 4, row 1 in column 3, and row 4 in column 0. Row 5 puts it in column 4 again.
- R4: The data commands use the column found by taking position L mod 4 and adding one when the position is at or past the parity column. This fills the non-parity columns left to right in increasing logical order.
- R5: The four commands of a write come in a fixed order, one accepted handshake each. The order is: read data (`cmd_write` = 0), read parity (`cmd_write` = 0), write data (`cmd_write` = 1), write parity (`cmd_write` = 1). A read command is followed by no further command until its response strobe has arrived.
- R6: The data write carries the new data word of the logical write.
- R7: The parity write carries old parity XOR old data XOR new data. Here old data and old parity are the words returned by the two reads.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command and all its fields stay unchanged on the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the parity write is accepted. `wr_ready` is low from the cycle after a write is accepted until the end of that write.
- R10: After any sequence of writes to an array whose rows each XOR to zero, every row still XORs to zero across all five columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A logical write is offered |
| wr_ready | output | 1 | Block is idle and takes the write |
| wr_lba | input | LBA_W | Logical block number of the write |
| wr_data | input | DATA_W | New data word |
| cmd_valid | output | 1 | Physical command offered |
| cmd_ready | input | 1 | Disk port accepts the command |
| cmd_col | output | COL_W | Disk column of the command |
| cmd_row | output | LBA_W | Stripe row of the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_wdata | output | DATA_W | Word to store for a write |
| rsp_valid | input | 1 | One-cycle read response strobe |
| rsp_data | input | DATA_W | Word returned by the read |
| done | output | 1 | One-cycle completion pulse |

## Verification
A sweep over logical blocks 0 to 24 runs the mapping through all five parity positions, and then into row 5, where the rotation wraps. This separates a wrong rotation direction, a wrong skip rule and a missing wrap. Random writes over 64 rows are run with random acceptance stalls and delayed read responses. They show whether the parity arithmetic and the handshake hold when command fields must stay put. Repeated writes to the same block show whether the sequencer reads back words it has just written. The final row-XOR sweep separates a correct parity update from one that only looks right command by command.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_D,
    S_WT_D,
    S_RD_P,
    S_WT_P,
    S_WR_D,
    S_WR_P
  } seq_state_t;
endpackage

// File: rtl/stripe_map.sv
module stripe_map #(
  parameter int NCOL  = 5,
  parameter int LBA_W = 8,
  parameter int COL_W = $clog2(NCOL)
) (
  input  logic [LBA_W-1:0] lba,
  output logic [LBA_W-1:0] row,
  output logic [COL_W-1:0] dcol,
  output logic [COL_W-1:0] pcol
);
  localparam int DCOLS = NCOL - 1;

  logic [COL_W-1:0] pos;
  logic [COL_W-1:0] rmod;

  always_comb begin
    row  = lba / LBA_W'(DCOLS);
    pos  = COL_W'(lba % LBA_W'(DCOLS));
    rmod = COL_W'(row % LBA_W'(NCOL));
    pcol = COL_W'(NCOL - 1) - rmod;
    dcol = (pos >= pcol) ? pos + COL_W'(1) : pos;
  end
endmodule

// File: rtl/parity_acc.sv
module parity_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_en,
  input  logic              fold_en,
  input  logic [DATA_W-1:0] seed_val,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (seed_en) acc <= din ^ seed_val;
    else if (fold_en) acc <= acc ^ din;
  end
endmodule

// File: rtl/write_seq.sv
module write_seq
  import stripe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  input  logic cmd_ready,
  input  logic rsp_valid,
  output logic wr_ready,
  output logic capture,
  output logic cmd_valid,
  output logic cmd_write,
  output logic sel_par,
  output logic seed_en,
  output logic fold_en,
  output logic done
);
  seq_state_t state_q, state_d;
  logic       done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    seed_en = 1'b0;
    fold_en = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      S_IDLE: if (wr_valid) begin capture = 1'b1; state_d = S_RD_D; end
      S_RD_D: if (cmd_ready) state_d = S_WT_D;
      S_WT_D: if (rsp_valid) begin seed_en = 1'b1; state_d = S_RD_P; end
      S_RD_P: if (cmd_ready) state_d = S_WT_P;
      S_WT_P: if (rsp_valid) begin fold_en = 1'b1; state_d = S_WR_D; end
      S_WR_D: if (cmd_ready) state_d = S_WR_P;
      S_WR_P: if (cmd_ready) begin done_d = 1'b1; state_d = S_IDLE; end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  assign wr_ready  = (state_q == S_IDLE);
  assign cmd_valid = (state_q == S_RD_D) || (state_q == S_RD_P) ||
                     (state_q == S_WR_D) || (state_q == S_WR_P);
  assign cmd_write = (state_q == S_WR_D) || (state_q == S_WR_P);
  assign sel_par   = (state_q == S_RD_P) || (state_q == S_WR_P);
endmodule

// File: rtl/parity_stripe_writer.sv
module parity_stripe_writer #(
  parameter int NCOL   = 5,
  parameter int LBA_W  = 8,
  parameter int DATA_W = 16,
  parameter int COL_W  = $clog2(NCOL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [LBA_W-1:0]  wr_lba,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [COL_W-1:0]  cmd_col,
  output logic [LBA_W-1:0]  cmd_row,
  output logic              cmd_write,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done
);
  logic [LBA_W-1:0]  map_row;
  logic [COL_W-1:0]  map_dcol, map_pcol;
  logic [LBA_W-1:0]  row_q;
  logic [COL_W-1:0]  dcol_q, pcol_q;
  logic [DATA_W-1:0] data_q, acc;
  logic              capture, sel_par, seed_en, fold_en;

  stripe_map #(.NCOL(NCOL), .LBA_W(LBA_W), .COL_W(COL_W)) u_map (
    .lba(wr_lba), .row(map_row), .dcol(map_dcol), .pcol(map_pcol)
  );

  write_seq u_seq (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .wr_ready(wr_ready), .capture(capture),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .sel_par(sel_par),
    .seed_en(seed_en), .fold_en(fold_en), .done(done)
  );

  parity_acc #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .seed_en(seed_en), .fold_en(fold_en),
    .seed_val(data_q), .din(rsp_data), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      dcol_q <= '0;
      pcol_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      row_q  <= map_row;
      dcol_q <= map_dcol;
      pcol_q <= map_pcol;
      data_q <= wr_data;
    end
  end

  assign cmd_row   = row_q;
  assign cmd_col   = sel_par ? pcol_q : dcol_q;
  assign cmd_wdata = sel_par ? acc : data_q;
endmodule

// File: rtl/stripe_writer_chk.sv
module stripe_writer_chk #(
  parameter int NCOL   = 5,
  parameter int LBA_W  = 8,
  parameter int DATA_W = 16,
  parameter int COL_W  = $clog2(NCOL)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [COL_W-1:0]  cmd_col,
  input logic [LBA_W-1:0]  cmd_row,
  input logic              cmd_write,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              rsp_valid,
  input logic              done
);
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_col) && $stable(cmd_row)
                                   && $stable(cmd_write) && $stable(cmd_wdata)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cmd_valid && cmd_ready && cmd_write));
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !wr_ready);
  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_col < COL_W'(NCOL)));
  // R5
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cmd_valid);
endmodule

bind parity_stripe_writer stripe_writer_chk #(
  .NCOL(NCOL), .LBA_W(LBA_W), .DATA_W(DATA_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_ready(wr_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_col(cmd_col), .cmd_row(cmd_row),
  .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
  .done(done)
);

// File: tb/parity_stripe_writer_test.sv
module parity_stripe_writer_test;
  localparam int NCOL = 5, LBA_W = 8, DATA_W = 16, COL_W = 3;
  localparam int ROWS = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_valid = 1'b0, wr_ready;
  logic [LBA_W-1:0] wr_lba = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic cmd_valid, cmd_ready = 1'b0, cmd_write, done;
  logic [COL_W-1:0] cmd_col;
  logic [LBA_W-1:0] cmd_row;
  logic [DATA_W-1:0] cmd_wdata;
  logic rsp_valid = 1'b0;
  logic [DATA_W-1:0] rsp_data = '0;

  parity_stripe_writer #(.NCOL(NCOL), .LBA_W(LBA_W), .DATA_W(DATA_W), .COL_W(COL_W)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_lba(wr_lba), .wr_data(wr_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_col(cmd_col), .cmd_row(cmd_row),
    .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .done(done)
  );

  always #5 clk = ~clk;

  typedef struct {
    int kind; int col; int row; bit wr; logic [DATA_W-1:0] wdata;
  } exp_cmd_t;

  exp_cmd_t sbq[$];
  logic [DATA_W-1:0] mem [ROWS][NCOL];
  int checks = 0, fails = 0;
  int pend = 0;
  logic [DATA_W-1:0] pend_word;
  int cycles = 0;
  bit finished = 0;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Independent placement: walk the row's columns and count data slots.
  task automatic place(input int lba, output int row, output int dcol, output int pcol);
    int pos, k;
    row  = lba / (NCOL - 1);
    pos  = lba % (NCOL - 1);
    pcol = (NCOL - 1) - (row % NCOL);
    k = 0; dcol = -1;
    for (int c = 0; c < NCOL; c++) begin
      if (c != pcol) begin
        if (k == pos) dcol = c;
        k++;
      end
    end
  endtask

  // Disk port model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin rsp_valid = 1'b1; rsp_data = pend_word; end
      end
      cmd_ready = ($urandom_range(0, 3) != 0);
      if (cmd_valid && cmd_ready) begin
        checks++;
        if (sbq.size() == 0) begin
          fails++;
          $display("FAIL R5: unexpected command col=%0d row=%0d wr=%0d, expected none",
                   cmd_col, cmd_row, cmd_write);
        end else begin
          exp_cmd_t e;
          e = sbq.pop_front();
          if (int'(cmd_row) != e.row) begin
            fails++;
            $display("FAIL R2: step %0d row %0d, expected %0d", e.kind, cmd_row, e.row);
          end else if (int'(cmd_col) != e.col) begin
            fails++;
            $display("FAIL %s: step %0d col %0d, expected %0d",
                     (e.kind % 2) ? "R3" : "R4", e.kind, cmd_col, e.col);
          end else if (cmd_write != e.wr) begin
            fails++;
            $display("FAIL R5: step %0d write flag %0d, expected %0d", e.kind, cmd_write, e.wr);
          end else if (e.wr && cmd_wdata !== e.wdata) begin
            fails++;
            $display("FAIL %s: step %0d word %h, expected %h",
                     (e.kind == 3) ? "R7" : "R6", e.kind, cmd_wdata, e.wdata);
          end
        end
        if (cmd_write) mem[cmd_row][cmd_col] = cmd_wdata;
        else begin pend = 2; pend_word = mem[cmd_row][cmd_col]; end
      end
    end
  end

  task automatic do_write(input int lba, input logic [DATA_W-1:0] d);
    int row, dcol, pcol, t;
    exp_cmd_t e;
    place(lba, row, dcol, pcol);
    e.row = row;
    e.kind = 0; e.col = dcol; e.wr = 0; e.wdata = '0; sbq.push_back(e);
    e.kind = 1; e.col = pcol; e.wr = 0; sbq.push_back(e);
    e.kind = 2; e.col = dcol; e.wr = 1; e.wdata = d; sbq.push_back(e);
    e.kind = 3; e.col = pcol; e.wr = 1;
    e.wdata = mem[row][pcol] ^ mem[row][dcol] ^ d; sbq.push_back(e);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_lba = LBA_W'(lba); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    checks++;
    if (wr_ready !== 1'b0) begin
      fails++;
      $display("FAIL R9: wr_ready %0b while busy, expected 0", wr_ready);
    end
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    checks++;
    if (!done) begin
      fails++;
      $display("FAIL R9: done %0b after write to %0d, expected 1", done, lba);
    end
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R5: %0d commands missing, expected 0", sbq.size());
      sbq.delete();
    end
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      logic [DATA_W-1:0] x;
      x = '0;
      for (int c = 0; c < NCOL - 1; c++) begin
        mem[r][c] = DATA_W'($urandom);
        x ^= mem[r][c];
      end
      mem[r][NCOL-1] = x;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (cmd_valid !== 1'b0 || done !== 1'b0 || wr_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: valid=%0b done=%0b ready=%0b, expected 0 0 1",
               cmd_valid, done, wr_ready);
    end
    rst = 1'b0;
    // R2 R3 R4: sweep through every parity position and the wrap into row 5
    for (int l = 0; l < 25; l++) do_write(l, DATA_W'(l * 7 + 3));
    // R6 R7: repeated writes to one block
    do_write(3, 16'hA5A5);
    do_write(3, 16'h0F0F);
    // R8: random writes under random stalls
    for (int n = 0; n < 60; n++) do_write($urandom_range(0, 255), DATA_W'($urandom));
    // R10: every row XORs to zero
    for (int r = 0; r < ROWS; r++) begin
      logic [DATA_W-1:0] x;
      x = '0;
      for (int c = 0; c < NCOL; c++) x ^= mem[r][c];
      checks++;
      if (x !== '0) begin
        fails++;
        $display("FAIL R10: row %0d xor %h, expected 0000", r, x);
      end
    end
    finished = 1;
    report();
  end

  initial begin
    while (!finished && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: %0d cycles, expected completion", cycles);
      report();
    end
  end
endmodule